// File: doc/BRIEF.md
# Phase-Shifted Carrier PWM Modulator

This block drives the gates of a cascaded H-bridge inverter with `LEVELS` output steps. It runs `LEVELS-1` triangular carriers that share one period and one amplitude. Each carrier is a counter that walks from 0 up to the period value and back down, one count per clock. On the first clock after reset is released, each carrier is started at its own fixed phase point. Because of these start points, neighbouring carriers are spread evenly over one full carrier cycle (for seven levels, six carriers sit 60 degrees apart). Every bridge leg therefore switches the same number of times and carries the same share of the load.

A signed sine sample arrives on an input port. The block captures it only when carrier 0 reaches its peak or its valley, and holds it in between, so that one sample cannot cross a carrier twice within a half period. Each carrier is compared with the held sample and gives one registered gate bit. The first half of the carriers drive the positive legs and compare the sample directly. The second half drive the negative legs and compare the negated sample. The block also reports the signed output level that the gate pattern produces. The ratio of reference frequency to carrier frequency is set by how fast the source supplies samples compared with the programmed period.

Top module: `pspwm_gen`

## Requirements
- R1: While `rst_ni` is low, and on the first clock edge after it rises, every bit of `gate_o` is 0 and `level_o` is 0.
- R2: Write N = LEVELS-1, P = `period_i`, and ph_k for the phase count of carrier k, which takes values 0 to 2P-1. On the first rising edge with `rst_ni` high, ph_k is loaded with floor(k*2P/N). On every later edge, ph_k advances by 1 modulo 2P.
- R3: The count of carrier k is ph_k when ph_k <= P and 2P-ph_k otherwise. This gives a triangle from 0 to P that moves by exactly one count per clock. The bipolar carrier value is v_k = 2*count - P.
- R4: The held reference is loaded from `ref_i` on the start edge. After that, it is loaded on an edge only when carrier 0's count before that edge is 0 or P. On every other edge it keeps its value, whatever `ref_i` does.
- R5: For k < N/2 (positive legs), `gate_o[k]` becomes 1 when the held reference is strictly greater than v_k, and becomes 0 when it is strictly less.
- R6: For k >= N/2 (negative legs), `gate_o[k]` becomes 1 when the negated held reference is strictly greater than v_k, and becomes 0 when it is strictly less.
- R7: When the compared values are equal, `gate_o[k]` keeps its previous value.
- R8: `level_o` is a two's-complement number. It equals the number of set bits in `gate_o[N/2-1:0]` minus the number of set bits in `gate_o[N-1:N/2]`, so it always lies within plus or minus N/2.
- R9: Each gate bit is registered. The value seen after edge j comes from the carrier counts and the held reference as they stood after edge j-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Carrier peak count P (at least 1), held static outside reset |
| ref_i | input | REF_W | Signed reference sample |
| gate_o | output | LEVELS-1 | Registered comparator bits, positive legs in the low half |
| level_o | output | LVL_W | Signed output level |

## Verification
The bench builds the block with five levels: four carriers, a 4-bit count and a 6-bit reference. With these widths, the bench can sweep every reference value from below the negative peak to above the positive peak at several periods. It uses an even period, where the carriers can tie with even samples. It uses an odd period, where floor(k*2P/N) rounds down. It also uses period 1. A sample that changes every cycle shows whether values between peaks and valleys are ignored, and a cycle-accurate arithmetic model checks every gate bit and the level on every clock.

// File: rtl/pspwm_pkg.sv
package pspwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pspwm_carrier.sv
module pspwm_carrier
  import pspwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int N     = 6,
  parameter int IDX   = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int OFS_W = CNT_W + 2 + $clog2(N);

  logic [CNT_W-1:0] cnt_q, ld_cnt;
  dir_e             dir_q, ld_dir;
  logic [OFS_W-1:0] span, pos;

  // start point: floor(IDX * 2P / N) along the 2P-count cycle
  always_comb begin
    span = OFS_W'(period_i) << 1;
    pos  = (span * OFS_W'(IDX)) / OFS_W'(N);
    if (pos < OFS_W'(period_i)) begin
      ld_cnt = CNT_W'(pos);
      ld_dir = DIR_UP;
    end else begin
      ld_cnt = CNT_W'(span - pos);
      ld_dir = DIR_DN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!run_i) begin
      cnt_q <= ld_cnt;
      dir_q <= ld_dir;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + CNT_W'(1);
      dir_q <= ((cnt_q + CNT_W'(1)) == period_i) ? DIR_DN : DIR_UP;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
      dir_q <= (cnt_q == CNT_W'(1)) ? DIR_UP : DIR_DN;
    end
  end

  assign cnt_o = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= period_i);

  p_unit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |->
      ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q + CNT_W'(1) == $past(cnt_q))));
endmodule

// File: rtl/pspwm_cmp.sv
module pspwm_cmp #(
  parameter int W   = 14,
  parameter bit INV = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] car_i,
  output logic                gate_o
);
  logic signed [W-1:0] eff;
  logic                gt, eq, gate_q;

  assign eff = INV ? -ref_i : ref_i;
  assign gt  = eff > car_i;
  assign eq  = eff == car_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gate_q <= 1'b0;
    else if (run_i && !eq) gate_q <= gt;
  end

  assign gate_o = gate_q;

  p_tie_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i && eq) |-> $stable(gate_q));
endmodule

// File: rtl/pspwm_level.sv
module pspwm_level #(
  parameter int N     = 6,
  parameter int LVL_W = 4
) (
  input  logic [N-1:0]           gate_i,
  output logic signed [LVL_W-1:0] level_o
);
  localparam int HALF = N / 2;

  always_comb begin
    int acc;
    acc = 0;
    for (int k = 0; k < N; k++) begin
      if (gate_i[k]) acc = (k < HALF) ? acc + 1 : acc - 1;
    end
    level_o = LVL_W'(acc);
  end
endmodule

// File: rtl/pspwm_gen.sv
module pspwm_gen
  import pspwm_pkg::*;
#(
  parameter int LEVELS = 7,
  parameter int CNT_W  = 10,
  parameter int REF_W  = 12,
  localparam int N     = LEVELS - 1,
  localparam int HALF  = N / 2,
  localparam int LVL_W = $clog2(HALF + 1) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        period_i,
  input  logic signed [REF_W-1:0] ref_i,
  output logic [N-1:0]            gate_o,
  output logic signed [LVL_W-1:0] level_o
);
  localparam int CW = max_int(REF_W, CNT_W + 2) + 1;

  logic                 run_q;
  logic signed [CW-1:0] ref_q, ref_ext, per_ext;
  logic [CNT_W-1:0]     cnt [N];
  logic signed [CW-1:0] car [N];
  logic                 samp;

  assign ref_ext = $signed({{(CW-REF_W){ref_i[REF_W-1]}}, ref_i});
  assign per_ext = $signed({{(CW-CNT_W){1'b0}}, period_i});
  assign samp    = !run_q || (cnt[0] == '0) || (cnt[0] == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ref_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (samp) ref_q <= ref_ext;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_leg
    pspwm_carrier #(.CNT_W(CNT_W), .N(N), .IDX(k)) u_car (
      .clk_i, .rst_ni, .run_i(run_q), .period_i, .cnt_o(cnt[k])
    );

    assign car[k] = $signed({{(CW-CNT_W-1){1'b0}}, cnt[k], 1'b0}) - per_ext;

    pspwm_cmp #(.W(CW), .INV(k >= HALF)) u_cmp (
      .clk_i, .rst_ni, .run_i(run_q), .ref_i(ref_q), .car_i(car[k]),
      .gate_o(gate_o[k])
    );
  end

  pspwm_level #(.N(N), .LVL_W(LVL_W)) u_lvl (.gate_i(gate_o), .level_o(level_o));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (gate_o == '0 && level_o == '0));

  p_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$past(samp)) |-> $stable(ref_q));

  p_level_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o <= LVL_W'(HALF)) && (level_o >= -LVL_W'(HALF)));

  p_carrier_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> cnt[0] == '0);
endmodule

// File: tb/tb_pspwm_gen.sv
module tb_pspwm_gen;
  localparam int LEVELS = 5;
  localparam int CNT_W  = 4;
  localparam int REF_W  = 6;
  localparam int N      = LEVELS - 1;
  localparam int HALF   = N / 2;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [CNT_W-1:0]        period = 4'd8;
  logic signed [REF_W-1:0] ref_s = '0;
  logic [N-1:0]            gate;
  logic signed [2:0]       level;

  int errors = 0, checks = 0;
  bit done = 0;

  int pos_m [N];
  int gate_m [N];
  int ref_m, run_m, per_m;

  pspwm_gen #(.LEVELS(LEVELS), .CNT_W(CNT_W), .REF_W(REF_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .period_i(period), .ref_i(ref_s),
    .gate_o(gate), .level_o(level)
  );

  always #4 clk = ~clk;

  function automatic int tri_cnt(input int p, input int per);
    return (p <= per) ? p : 2 * per - p;
  endfunction

  // model of one clock edge, built from R2-R7 and R9
  task automatic model_edge();
    int newg [N];
    if (run_m == 0) begin
      for (int k = 0; k < N; k++) pos_m[k] = (k * 2 * per_m) / N;
      ref_m = int'(ref_s);
      run_m = 1;
    end else begin
      bit samp;
      samp = (tri_cnt(pos_m[0], per_m) == 0) || (tri_cnt(pos_m[0], per_m) == per_m);
      for (int k = 0; k < N; k++) begin
        int v, eff;
        v   = 2 * tri_cnt(pos_m[k], per_m) - per_m;
        eff = (k < HALF) ? ref_m : -ref_m;
        newg[k] = (eff > v) ? 1 : (eff < v) ? 0 : gate_m[k];
      end
      for (int k = 0; k < N; k++) begin
        gate_m[k] = newg[k];
        pos_m[k]  = (pos_m[k] + 1) % (2 * per_m);
      end
      if (samp) ref_m = int'(ref_s);
    end
  endtask

  task automatic check_out();
    int exp_lvl;
    logic [N-1:0] exp_g;
    exp_lvl = 0;
    for (int k = 0; k < N; k++) begin
      exp_g[k] = gate_m[k][0];
      if (gate_m[k] != 0) exp_lvl += (k < HALF) ? 1 : -1;
    end
    checks++;
    if (gate !== exp_g) begin
      errors++;
      $display("FAIL R2/R3/R4/R5/R6/R7/R9 gates P=%0d: got %b exp %b", per_m, gate, exp_g);
    end
    checks++;
    if (int'(level) != exp_lvl) begin
      errors++;
      $display("FAIL R8 level P=%0d: got %0d exp %0d", per_m, level, exp_lvl);
    end
  endtask

  task automatic restart(input int per);
    @(negedge clk);
    rst_ni = 1'b0;
    period = CNT_W'(per);
    per_m  = per;
    run_m  = 0;
    for (int k = 0; k < N; k++) gate_m[k] = 0;
    #1;
    checks++;
    if (gate !== '0 || level !== '0) begin
      errors++;
      $display("FAIL R1 reset: got gate=%b level=%0d exp 0 0", gate, level);
    end
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // mode 0: constant value; mode 1: changes every cycle; mode 2: triangle sweep
  task automatic run_cycles(input int ncyc, input int mode, input int val);
    for (int c = 0; c < ncyc; c++) begin
      case (mode)
        0: ref_s = REF_W'(val);
        1: ref_s = REF_W'(((c * 7) % 23) - 11);
        default: ref_s = REF_W'(((c / 3) % 20 < 10) ? (c / 3) % 20 - 5 : 15 - (c / 3) % 20);
      endcase
      @(posedge clk);
      #1 model_edge();
      @(negedge clk);
      check_out();
    end
  endtask

  initial begin
    int pers [4] = '{8, 5, 1, 6};
    per_m = 8;
    run_m = 0;
    for (int k = 0; k < N; k++) gate_m[k] = 0;
    foreach (pers[i]) begin
      for (int v = -pers[i] - 1; v <= pers[i] + 1; v++) begin
        restart(pers[i]);
        run_cycles(4 * pers[i] + 6, 0, v);
      end
      restart(pers[i]);
      run_cycles(200, 1, 0);
      restart(pers[i]);
      run_cycles(200, 2, 0);
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule